// File: doc/BRIEF.md
# Pipelined Eight-Lane Signed Sorter

This block takes eight signed 16-bit words in parallel on every clock and returns the same eight words in ascending order on eight parallel lanes. The ordering comes from a fixed odd-even merge network of nineteen compare-exchange cells arranged in six layers. Every layer is followed by a register, and both the inputs and the outputs are registered. Each result therefore appears a fixed eight clocks after its operands, and a fresh operand set can enter on every cycle.

The cells are the same for every input set, so there is no control flow that depends on the data. An optional qualifier bit, `in_vld`, travels through an eight-deep shift register beside the data. A consumer can use it to match each output set to the input set it came from. The qualifier never gates the data path.

Top module: `oem_sorter8`

## Requirements
- R1: Lane i of `in_data` and `out_data` occupies bits [16*i+15 : 16*i], and each lane is read as a two's-complement 16-bit integer.
- R2: For every set, the output lanes are in non-decreasing order: lane 0 holds the smallest value and lane 7 the largest.
- R3: Comparison is signed. Negative values come out below non-negative ones, -32768 is the smallest value possible and 32767 is the largest.
- R4: The output set is a permutation of the input set, and every repeated value keeps its multiplicity.
- R5: A set presented before clock edge k appears on `out_data` after edge k+7, which is eight registering edges. `out_vld` copies the `in_vld` of that same set and stays low on the cycle before.
- R6: A new set is accepted on every clock. Sets presented on consecutive cycles come out on consecutive cycles, in the same order, each correctly sorted.
- R7: Reset is synchronous and active high. One edge with `rst` high clears `out_data` and `out_vld` to zero, and drops every set that was in flight, so none of them ever shows `out_vld` high.
- R8: `in_vld` has no effect on the data path. A set presented with `in_vld` low still comes out sorted after eight edges, with `out_vld` low.
- R9: Input that is already sorted, including input in which all eight lanes are equal, comes out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Qualifier carried alongside the operand set |
| in_data | input | 128 | Eight signed operand lanes, lane i at bits [16i+15:16i] |
| out_vld | output | 1 | Qualifier of the set now on `out_data` |
| out_data | output | 128 | Eight sorted lanes, smallest in lane 0 |

## Verification
A cell wired to the wrong pair, or one that swaps in the wrong direction, leaves a stage register holding a mis-ordered or duplicated lane. This shows at the outputs as an unsorted set, or as a set whose sum differs from the input sum, exactly eight edges after the triggering operands. A stuck or missing pipeline register shifts the qualifier against the data, so `out_vld` rises one cycle early or late. Reset faults appear as non-zero outputs on the first cycle after the reset edge, or as stale sets emerging with `out_vld` high afterwards.

// File: rtl/oem_pkg.sv
package oem_pkg;

  // Network geometry is fixed by the merge schedule for eight lanes.
  localparam int LANES  = 8;
  localparam int LAYERS = 6;
  // input register + one register per layer + output register
  localparam int DEPTH  = LAYERS + 2;

  // Partner lane of `lane` in network layer `layer` (0-based), -1 if idle.
  function automatic int partner(input int layer, input int lane);
    int p;
    p = -1;
    case (layer)
      0: p = lane ^ 1;
      1: p = lane ^ 2;
      2: begin
        case (lane)
          1: p = 2;
          2: p = 1;
          5: p = 6;
          6: p = 5;
          default: p = -1;
        endcase
      end
      3: p = lane ^ 4;
      4: begin
        case (lane)
          2: p = 4;
          3: p = 5;
          4: p = 2;
          5: p = 3;
          default: p = -1;
        endcase
      end
      5: begin
        if (lane == 0 || lane == LANES - 1) p = -1;
        else if (lane % 2 == 1) p = lane + 1;
        else p = lane - 1;
      end
      default: p = -1;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/oem_cx_cell.sv
module oem_cx_cell #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);

  logic swap;

  // Signed compare; equal operands keep their lanes.
  assign swap = $signed(a) > $signed(b);
  assign lo   = swap ? b : a;
  assign hi   = swap ? a : b;

endmodule

// File: rtl/oem_layer.sv
module oem_layer #(
  parameter int W     = 16,
  parameter int LAYER = 0
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [oem_pkg::LANES-1:0][W-1:0]  d,
  output logic [oem_pkg::LANES-1:0][W-1:0]  q
);

  localparam int LANES = oem_pkg::LANES;

  logic [LANES-1:0][W-1:0] nx;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int P = oem_pkg::partner(LAYER, l);
    if (P > l) begin : g_cell
      oem_cx_cell #(.W(W)) u_cx (
        .a  (d[l]),
        .b  (d[P]),
        .lo (nx[l]),
        .hi (nx[P])
      );
    end else if (P < 0) begin : g_pass
      assign nx[l] = d[l];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nx;
  end

endmodule

// File: rtl/oem_sorter8.sv
module oem_sorter8 #(
  parameter int W = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_vld,
  input  logic [oem_pkg::LANES*W-1:0]   in_data,
  output logic                          out_vld,
  output logic [oem_pkg::LANES*W-1:0]   out_data
);

  localparam int LANES  = oem_pkg::LANES;
  localparam int LAYERS = oem_pkg::LAYERS;
  localparam int DEPTH  = oem_pkg::DEPTH;

  // lvl[0] is the input register, lvl[n] the register after layer n.
  logic [LAYERS:0][LANES-1:0][W-1:0] lvl;
  logic [LANES-1:0][W-1:0]           out_q;
  logic [DEPTH-1:0]                  vsr;

  always_ff @(posedge clk) begin
    if (rst) lvl[0] <= '0;
    else     lvl[0] <= in_data;
  end

  for (genvar s = 0; s < LAYERS; s++) begin : g_layer
    oem_layer #(.W(W), .LAYER(s)) u_layer (
      .clk (clk),
      .rst (rst),
      .d   (lvl[s]),
      .q   (lvl[s+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      vsr   <= '0;
    end else begin
      out_q <= lvl[LAYERS];
      vsr   <= {vsr[DEPTH-2:0], in_vld};
    end
  end

  assign out_data = out_q;
  assign out_vld  = vsr[DEPTH-1];

endmodule

// File: rtl/oem_sorter8_chk.sv
module oem_sorter8_chk #(
  parameter int W = 16
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        in_vld,
  input logic [oem_pkg::LANES*W-1:0] in_data,
  input logic                        out_vld,
  input logic [oem_pkg::LANES*W-1:0] out_data
);

  localparam int LANES = oem_pkg::LANES;
  localparam int SW    = W + 4;

  function automatic logic is_sorted(input logic [LANES*W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < LANES - 1; i++)
      if ($signed(v[i*W +: W]) > $signed(v[(i+1)*W +: W])) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic [SW-1:0] lane_sum(input logic [LANES*W-1:0] v);
    logic signed [SW-1:0] s;
    s = '0;
    for (int i = 0; i < LANES; i++) s = s + SW'($signed(v[i*W +: W]));
    return s;
  endfunction

  logic [3:0] since_rst = 4'd0;
  logic       prev_rst  = 1'b0;
  logic [SW-1:0] in_sum, out_sum;

  assign in_sum  = lane_sum(in_data);
  assign out_sum = lane_sum(out_data);

  always @(posedge clk) begin
    if (rst) since_rst <= 4'd0;
    else if (since_rst != 4'd8) since_rst <= since_rst + 4'd1;
    prev_rst <= rst;
  end

  // R2, R3: outputs always in signed non-decreasing order
  p_sorted_r2: assert property (@(posedge clk) disable iff (rst)
    is_sorted(out_data));

  // R4: sum preserved across the eight-edge pipeline
  p_perm_sum_r4: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 4'd8) |-> (out_sum == $past(in_sum, 8)));

  // R5: qualifier delayed by exactly eight edges
  p_vld_lat_r5: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 4'd8) |-> (out_vld == $past(in_vld, 8)));

  // R7: one reset edge clears the outputs
  always @(posedge clk) begin
    if (prev_rst) begin
      p_reset_clear_r7: assert (out_data == '0 && out_vld == 1'b0);
    end
  end

endmodule

bind oem_sorter8 oem_sorter8_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_vld   (in_vld),
  .in_data  (in_data),
  .out_vld  (out_vld),
  .out_data (out_data)
);

// File: tb/test_oem_sorter8.sv
`timescale 1ns/1ps
module test_oem_sorter8;

  localparam int W = 16;
  localparam int N = 8;
  typedef logic [N*W-1:0] vec_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  vec_t in_data = '0;
  logic out_vld;
  vec_t out_data;

  int total = 0;
  int bad   = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  oem_sorter8 #(.W(W)) i_oem_sorter8 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data),
    .out_vld(out_vld), .out_data(out_data)
  );

  function automatic vec_t pack8(input int a [N]);
    vec_t v;
    for (int i = 0; i < N; i++) v[i*W +: W] = a[i][W-1:0];
    return v;
  endfunction

  // Independent reference: insertion sort on signed integers.
  function automatic vec_t ref_sort(input vec_t v);
    int a [N];
    int t;
    int j;
    for (int i = 0; i < N; i++) a[i] = int'($signed(v[i*W +: W]));
    for (int i = 1; i < N; i++) begin
      t = a[i];
      j = i - 1;
      while (j >= 0 && a[j] > t) begin
        a[j+1] = a[j];
        j--;
      end
      a[j+1] = t;
    end
    return pack8(a);
  endfunction

  function automatic vec_t rnd_vec();
    vec_t v;
    for (int i = 0; i < N; i++) v[i*W +: W] = W'($urandom);
    return v;
  endfunction

  task automatic chk_vec(input string req, input vec_t got, input vec_t exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_bit(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  // One set, then idle; checks latency edge and result.
  task automatic run_one(input string req, input vec_t v, input logic vld,
                         input vec_t exp);
    @(negedge clk);
    in_data = v;
    in_vld  = vld;
    @(negedge clk);
    in_vld  = 1'b0;
    in_data = rnd_vec();
    repeat (6) @(negedge clk);
    chk_bit({req, " R5 vld not early"}, out_vld, 1'b0);
    @(negedge clk);
    chk_bit({req, " R5 vld"}, out_vld, vld);
    chk_vec({req, " data"}, out_data, exp);
  endtask

  task automatic t_reset();
    in_vld  = 1'b1;
    in_data = rnd_vec();
    rst     = 1'b1;
    repeat (3) @(negedge clk);
    chk_vec("R7 reset data", out_data, '0);
    chk_bit("R7 reset vld", out_vld, 1'b0);
    rst    = 1'b0;
    in_vld = 1'b0;
    repeat (9) @(negedge clk);
    chk_bit("R7 idle after reset", out_vld, 1'b0);
  endtask

  task automatic t_patterns();
    vec_t v;
    v = pack8('{7, 6, 5, 4, 3, 2, 1, 0});
    run_one("R2 R1 reversed", v, 1'b1, pack8('{0, 1, 2, 3, 4, 5, 6, 7}));
    v = pack8('{-5, 3, 0, -1, 12, -300, 8, 2});
    run_one("R2 mixed", v, 1'b1, ref_sort(v));
    v = pack8('{32767, -32768, 1, -1, 0, 32766, -32767, 0});
    run_one("R3 signed extremes", v, 1'b1,
            pack8('{-32768, -32767, -1, 0, 0, 1, 32766, 32767}));
    v = pack8('{4, 9, 4, 4, -2, 9, -2, 4});
    run_one("R4 duplicates", v, 1'b1, pack8('{-2, -2, 4, 4, 4, 4, 9, 9}));
    v = pack8('{-9, -3, 0, 1, 1, 20, 400, 30000});
    run_one("R9 presorted", v, 1'b1, v);
    v = pack8('{-77, -77, -77, -77, -77, -77, -77, -77});
    run_one("R9 all equal", v, 1'b1, v);
  endtask

  task automatic t_novld();
    vec_t v;
    v = rnd_vec();
    run_one("R8 in_vld low", v, 1'b0, ref_sort(v));
  endtask

  task automatic t_stream();
    vec_t sv [20];
    for (int k = 0; k < 20; k++) sv[k] = rnd_vec();
    for (int c = 0; c < 28; c++) begin
      @(negedge clk);
      if (c >= 8) begin
        chk_bit("R6 stream vld", out_vld, 1'b1);
        chk_vec("R6 stream data", out_data, ref_sort(sv[c-8]));
      end
      if (c < 20) begin
        in_data = sv[c];
        in_vld  = 1'b1;
      end else begin
        in_vld  = 1'b0;
      end
    end
    @(negedge clk);
    chk_bit("R6 stream end", out_vld, 1'b0);
  endtask

  task automatic t_midreset();
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      in_data = rnd_vec();
      in_vld  = 1'b1;
    end
    @(negedge clk);
    in_vld = 1'b0;
    rst    = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk_vec("R7 mid reset data", out_data, '0);
    chk_bit("R7 mid reset vld", out_vld, 1'b0);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      chk_bit("R7 flushed set", out_vld, 1'b0);
    end
  endtask

  initial begin
    void'($urandom(32'd1357));
    t_reset();
    t_patterns();
    t_novld();
    t_stream();
    t_midreset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule